// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Code Loader

This block is the digital front end of a two-channel 12-bit converter, modelled synchronously. A host writes over an 8-bit parallel bus. The bus has an active-low select, an active-low write strobe and a 2-bit address. The address steers each write into one of four staging registers: a low byte and a high nibble for each of the two channels. The host may fill the staging registers in any order. None of these writes reaches the converter codes while the active-low update strobe is held high.

While the update strobe is low, both channel codes follow their staging registers. The codes keep whatever was staged when the strobe returns high. All strobes are asynchronous to the system clock, so they pass through a synchronizer first. Edges and pulse widths are then measured in clock cycles.

The update strobe may overlap a write. In that case it must stay low for at least `MIN_PULSE` cycles after the write ends. If it rises earlier, the block raises a hazard flag and puts back the codes that were held before the update pulse began.

Top module: `dual_dac_loader`

## Requirements
- R1: Reset clears all four staging registers, both channel codes and the hazard flag to zero.
- R2: Address 0 writes the channel A low byte, 1 the channel A high nibble, 2 the channel B low byte, 3 the channel B high nibble. At most one staging register is written per cycle.
- R3: A staging register is written only while both `bus_sel_n` and `bus_wr_n` are low. A cycle with either of them high changes no staging register.
- R4: A low-byte write stores all of `bus_data[7:0]` as code bits 7:0. A high-nibble write stores only `bus_data[3:0]` as code bits 11:8, and `bus_data[7:4]` are ignored.
- R5: While `upd_n` stays high, writes to any staging register, in any order, leave `code_a` and `code_b` unchanged.
- R6: While `upd_n` is low, each code follows its staging registers. After `upd_n` rises, each code keeps the value staged at that moment.
- R7: Both channels update in the same clock cycle, each from its own staging registers.
- R8: Suppose an update pulse overlaps a write, and `upd_n` rises fewer than `MIN_PULSE` cycles after the write ends. Then `upd_hazard` is set, and both codes return to the values they held before that update pulse began.
- R9: An update pulse that stays low for `MIN_PULSE` or more cycles after an overlapping write ends commits the staged values. Every clean rise of `upd_n` clears `upd_hazard`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel_n | input | 1 | Active-low select, asynchronous |
| bus_wr_n | input | 1 | Active-low write strobe, asynchronous |
| bus_addr | input | 2 | Staging register select |
| bus_data | input | 8 | Write data, right-justified |
| upd_n | input | 1 | Active-low update strobe, asynchronous |
| code_a | output | 12 | Channel A converter code |
| code_b | output | 12 | Channel B converter code |
| upd_hazard | output | 1 | Last update ended too soon after an overlapping write |

## Verification
A staging register that is corrupted stays invisible while `upd_n` is high. It shows up on `code_a` or `code_b` only at the next update, about four clock cycles after `upd_n` falls. For that reason every negative write case is followed by an update pulse that exposes the staging contents. A fault in the overlap counter is different: it shows only at the rising edge of `upd_n`, as a wrong hazard flag together with a code that was either restored or committed when it should have been the other. The boundary gaps of `MIN_PULSE-1` and `MIN_PULSE` cycles pin that comparison down.

// File: rtl/dacld_pkg.sv
package dacld_pkg;

    localparam int BYTE_W = 8;
    localparam int HI_W   = 4;
    localparam int CODE_W = BYTE_W + HI_W;
    localparam int NCH    = 2;
    localparam int ADDR_W = 2;
    localparam int SLOTS  = 2 * NCH;

    // One channel's staged or committed code
    typedef struct packed {
        logic [HI_W-1:0]   hi;
        logic [BYTE_W-1:0] lo;
    } word_t;

    // Asynchronous bus bundle carried through the synchronizer
    typedef struct packed {
        logic              sel_n;
        logic              wr_n;
        logic              upd_n;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } bus_t;

    localparam bus_t BUS_IDLE = '{sel_n: 1'b1, wr_n: 1'b1, upd_n: 1'b1,
                                  addr: '0, data: '0};

    // slot index = channel*2 + (1 for high nibble)
    function automatic logic [SLOTS-1:0] slot_decode(input logic [ADDR_W-1:0] a);
        logic [SLOTS-1:0] v;
        v    = '0;
        v[a] = 1'b1;
        return v;
    endfunction

    function automatic logic [CODE_W-1:0] to_code(input word_t w);
        return {w.hi, w.lo};
    endfunction

endpackage

// File: rtl/dacld_sync.sv
module dacld_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dacld_bank.sv
module dacld_bank
    import dacld_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_act,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [BYTE_W-1:0]    data,
    output logic [SLOTS-1:0]     slot_en,
    output word_t [NCH-1:0]      words
);
    assign slot_en = wr_act ? slot_decode(addr) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            words <= '0;
        end else begin
            for (int ch = 0; ch < NCH; ch++) begin
                if (slot_en[2*ch])   words[ch].lo <= data;
                if (slot_en[2*ch+1]) words[ch].hi <= data[HI_W-1:0];
            end
        end
    end
endmodule

// File: rtl/dacld_upd.sv
module dacld_upd #(
    parameter int MIN_PULSE = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic upd_n_s,
    input  logic wr_act,
    output logic xparent,
    output logic capture,
    output logic rise,
    output logic restore,
    output logic hazard
);
    localparam int GAP_W = $clog2(MIN_PULSE + 1);
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(MIN_PULSE);

    logic             low_q;
    logic             ovl_q;
    logic [GAP_W-1:0] gap_q;

    assign xparent = !upd_n_s;
    assign capture = xparent && !low_q;
    assign rise    = !xparent && low_q;
    assign restore = rise && ovl_q && (gap_q < GAP_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            low_q  <= 1'b0;
            ovl_q  <= 1'b0;
            gap_q  <= '0;
            hazard <= 1'b0;
        end else begin
            low_q <= xparent;
            if (capture) begin
                ovl_q <= wr_act;
                gap_q <= '0;
            end else if (xparent) begin
                if (wr_act) begin
                    ovl_q <= 1'b1;
                    gap_q <= '0;
                end else if (ovl_q && gap_q < GAP_MAX) begin
                    gap_q <= gap_q + 1'b1;
                end
            end
            if (rise) hazard <= restore;
        end
    end
endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
    import dacld_pkg::*;
#(
    parameter int MIN_PULSE   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel_n,
    input  logic              bus_wr_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_data,
    input  logic              upd_n,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b,
    output logic              upd_hazard
);
    bus_t             bus_raw;
    bus_t             bus_s;
    logic             wr_act;
    logic [SLOTS-1:0] slot_en;
    word_t [NCH-1:0]  in_words;
    word_t [NCH-1:0]  dac_words;
    logic             xparent, capture, rise, restore;

    assign bus_raw = '{sel_n: bus_sel_n, wr_n: bus_wr_n, upd_n: upd_n,
                       addr: bus_addr, data: bus_data};

    dacld_sync #(
        .W       ($bits(bus_t)),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (BUS_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (bus_raw),
        .q   (bus_s)
    );

    assign wr_act = !bus_s.sel_n && !bus_s.wr_n;

    dacld_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_act  (wr_act),
        .addr    (bus_s.addr),
        .data    (bus_s.data),
        .slot_en (slot_en),
        .words   (in_words)
    );

    dacld_upd #(.MIN_PULSE(MIN_PULSE)) u_upd (
        .clk     (clk),
        .rst     (rst),
        .upd_n_s (bus_s.upd_n),
        .wr_act  (wr_act),
        .xparent (xparent),
        .capture (capture),
        .rise    (rise),
        .restore (restore),
        .hazard  (upd_hazard)
    );

    // Per-channel committed code with a snapshot taken when the update pulse opens
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        word_t cur_q;
        word_t snap_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                cur_q  <= '0;
                snap_q <= '0;
            end else begin
                if (capture) snap_q <= cur_q;
                if (xparent)      cur_q <= in_words[ch];
                else if (restore) cur_q <= snap_q;
            end
        end
        assign dac_words[ch] = cur_q;
    end

    assign code_a = to_code(dac_words[0]);
    assign code_b = to_code(dac_words[1]);
endmodule

// File: rtl/dacld_chk.sv
module dacld_chk
    import dacld_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                wr_act,
    input logic                xparent,
    input logic                restore,
    input logic                rise,
    input logic                hazard,
    input logic [CODE_W-1:0]   code_a,
    input logic [CODE_W-1:0]   code_b,
    input logic [SLOTS-1:0]    slot_en,
    input logic [NCH*CODE_W-1:0] words
);
    // R2
    slot_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(slot_en));

    // R3
    no_write_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_act |=> $stable(words));

    // R5
    hold_codes_chk: assert property (@(posedge clk) disable iff (rst)
        (!xparent && !restore) |=> ($stable(code_a) && $stable(code_b)));

    // R6
    follow_stage_chk: assert property (@(posedge clk) disable iff (rst)
        xparent |=> ({code_b, code_a} == $past(words)));

    // R8
    restore_flag_chk: assert property (@(posedge clk) disable iff (rst)
        restore |=> hazard);

    // R9
    flag_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(hazard));
endmodule

bind dual_dac_loader dacld_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_act  (wr_act),
    .xparent (xparent),
    .restore (restore),
    .rise    (rise),
    .hazard  (upd_hazard),
    .code_a  (code_a),
    .code_b  (code_b),
    .slot_en (slot_en),
    .words   (in_words)
);

// File: tb/dual_dac_loader_test.sv
`timescale 1ns/1ps
module dual_dac_loader_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel_n = 1'b1;
    logic        bus_wr_n = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic        upd_n = 1'b1;
    logic [11:0] code_a, code_b;
    logic        upd_hazard;

    int nchk = 0;
    int nfail = 0;

    always #2.5 clk = ~clk;

    dual_dac_loader #(.MIN_PULSE(4), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .bus_sel_n(bus_sel_n), .bus_wr_n(bus_wr_n),
        .bus_addr(bus_addr), .bus_data(bus_data), .upd_n(upd_n),
        .code_a(code_a), .code_b(code_b), .upd_hazard(upd_hazard)
    );

    localparam logic [2:0] K_WR = 3'd0, K_NOSEL = 3'd1, K_NOWR = 3'd2,
                           K_LOAD = 3'd3, K_OVL = 3'd4;

    typedef struct packed {
        logic [2:0]  kind;
        logic [1:0]  addr;
        logic [7:0]  data;
        logic [3:0]  arg;   // low cycles for a load, gap for an overlap
        logic [11:0] ea;
        logic [11:0] eb;
        logic        ee;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{K_WR,    2'd0, 8'h5A, 4'd0, 12'h000, 12'h000, 1'b0}, // R5 A low
        '{K_WR,    2'd3, 8'hF7, 4'd0, 12'h000, 12'h000, 1'b0}, // R5 B high
        '{K_WR,    2'd2, 8'h3C, 4'd0, 12'h000, 12'h000, 1'b0}, // R5 B low
        '{K_WR,    2'd1, 8'hE9, 4'd0, 12'h000, 12'h000, 1'b0}, // R5 A high
        '{K_LOAD,  2'd0, 8'h00, 4'd3, 12'h95A, 12'h73C, 1'b0}, // R2 R4 R7
        '{K_NOSEL, 2'd0, 8'hFF, 4'd0, 12'h95A, 12'h73C, 1'b0}, // R3
        '{K_LOAD,  2'd0, 8'h00, 4'd2, 12'h95A, 12'h73C, 1'b0}, // R3 exposed
        '{K_NOWR,  2'd2, 8'h00, 4'd0, 12'h95A, 12'h73C, 1'b0}, // R3
        '{K_LOAD,  2'd0, 8'h00, 4'd2, 12'h95A, 12'h73C, 1'b0}, // R3 exposed
        '{K_OVL,   2'd0, 8'h11, 4'd6, 12'h911, 12'h73C, 1'b0}, // R9
        '{K_OVL,   2'd2, 8'h22, 4'd1, 12'h911, 12'h73C, 1'b1}, // R8
        '{K_LOAD,  2'd0, 8'h00, 4'd3, 12'h911, 12'h722, 1'b0}, // R9 clears
        '{K_WR,    2'd1, 8'hA4, 4'd0, 12'h911, 12'h722, 1'b0}, // R4 upper bits
        '{K_LOAD,  2'd0, 8'h00, 4'd2, 12'h411, 12'h722, 1'b0}, // R4
        '{K_OVL,   2'd3, 8'h05, 4'd4, 12'h411, 12'h522, 1'b0}, // R9 boundary
        '{K_OVL,   2'd3, 8'h06, 4'd3, 12'h411, 12'h522, 1'b1}  // R8 boundary
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input string what,
                         input logic [11:0] act, input logic [11:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d,
                             input logic sel, input logic wr);
        bus_addr  = a;
        bus_data  = d;
        bus_sel_n = sel;
        bus_wr_n  = wr;
        tick(3);
        bus_sel_n = 1'b1;
        bus_wr_n  = 1'b1;
        tick(3);
    endtask

    task automatic pulse_load(input int n);
        upd_n = 1'b0;
        tick(n);
        upd_n = 1'b1;
        tick(6);
    endtask

    task automatic overlap(input logic [1:0] a, input logic [7:0] d, input int gap);
        upd_n = 1'b0;
        tick(1);
        bus_addr  = a;
        bus_data  = d;
        bus_sel_n = 1'b0;
        bus_wr_n  = 1'b0;
        tick(3);
        bus_sel_n = 1'b1;
        bus_wr_n  = 1'b1;
        tick(gap);
        upd_n = 1'b1;
        tick(6);
    endtask

    function automatic string tag_of(input logic [2:0] k);
        case (k)
            K_WR:    return "R5";
            K_NOSEL: return "R3";
            K_NOWR:  return "R3";
            K_LOAD:  return "R6";
            default: return "R8/R9";
        endcase
    endfunction

    initial begin
        #(5.0 * 20000);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        check("R1", "code_a", code_a, 12'h000);
        check("R1", "code_b", code_b, 12'h000);
        check("R1", "hazard", {11'd0, upd_hazard}, 12'h000);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].kind)
                K_WR:    bus_write(VEC[i].addr, VEC[i].data, 1'b0, 1'b0);
                K_NOSEL: bus_write(VEC[i].addr, VEC[i].data, 1'b1, 1'b0);
                K_NOWR:  bus_write(VEC[i].addr, VEC[i].data, 1'b0, 1'b1);
                K_LOAD:  pulse_load(int'(VEC[i].arg));
                default: overlap(VEC[i].addr, VEC[i].data, int'(VEC[i].arg));
            endcase
            check(tag_of(VEC[i].kind), "code_a", code_a, VEC[i].ea);
            check(tag_of(VEC[i].kind), "code_b", code_b, VEC[i].eb);
            check(tag_of(VEC[i].kind), "hazard", {11'd0, upd_hazard}, {11'd0, VEC[i].ee});
        end

        // R6 R7 transparent while low: both channels follow their staging registers
        upd_n = 1'b0;
        tick(6);
        check("R7", "code_b low", code_b, 12'h622);
        bus_write(2'd0, 8'h77, 1'b0, 1'b0);
        check("R6", "code_a low", code_a, 12'h477);
        check("R6", "hazard low", {11'd0, upd_hazard}, 12'h001);
        tick(3);
        upd_n = 1'b1;
        tick(6);
        check("R6", "code_a held", code_a, 12'h477);
        check("R9", "hazard clean", {11'd0, upd_hazard}, 12'h000);

        // R1 reset mid-run, then an update exposes the cleared staging registers
        bus_write(2'd3, 8'h0F, 1'b0, 1'b0);
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(1);
        check("R1", "code_a rst", code_a, 12'h000);
        check("R1", "code_b rst", code_b, 12'h000);
        pulse_load(2);
        check("R1", "code_a staged", code_a, 12'h000);
        check("R1", "code_b staged", code_b, 12'h000);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule